// File: doc/BRIEF.md
# DAC Channel Sample Holding Front End

This block is the digital side of one converter channel. A register-style write port delivers samples in one of three alignments. Each sample is normalised into a 12-bit holding register. The held value then moves into an output register, which drives the converter code. The move happens in one of three ways:

- automatically, right after a write;
- on a self-clearing software trigger;
- on the rising edge of one external trigger, picked by a select field.

The block also models the channel power-up handshake. Raising the enable starts a programmable wakeup count, and a ready flag reports when the channel will accept data. While the channel is enabled but not yet ready, writes and triggers have no effect and raise a sticky error flag. With the enable low the whole digital path works normally, because the enable only governs the analog side.

Top module: `dac_hold_front`

## Requirements
- R1: After reset, hold_q, out_code, ready, err_sticky and sw_pend are all zero.
- R2: A write with wr_fmt = 0 (8-bit right-aligned) places wr_data[7:0] into hold_q[11:4] and clears hold_q[3:0]. hold_q updates on the clock edge that samples wr_en.
- R3: A write with wr_fmt = 1 (12-bit left-aligned) places wr_data[15:4] into hold_q[11:0].
- R4: A write with wr_fmt = 2 (12-bit right-aligned) places wr_data[11:0] into hold_q[11:0].
- R5: A write with wr_fmt = 3 is reserved. It leaves hold_q unchanged and raises no error while the channel is not starting up.
- R6: With trig_en low, an accepted write reaches out_code one clock edge after hold_q takes it.
- R7: A sw_trig_set pulse sets sw_pend. With trig_en high and the channel not starting up, the next edge copies hold_q into out_code and clears sw_pend. With trig_en high, writes alone never change out_code.
- R8: With trig_en high, a rising edge on ext_trig[trig_sel] copies hold_q into out_code. The copy happens on the edge after the first edge that samples the input high. A steady high level, and edges on unselected inputs, cause no copy.
- R9: ready rises on the N-th consecutive clock edge that samples ch_en high, where N = max(wake_cycles, 1). ready falls at once when ch_en goes low.
- R10: While ch_en is high and ready is low, the following are ignored and set err_sticky: a write, a sw_trig_set, and (with trig_en high) a selected trigger edge. err_sticky stays set until reset.
- R11: With ch_en low, writes and transfers work normally and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write strobe |
| wr_fmt | input | 2 | Alignment code: 0 byte right, 1 word left, 2 word right, 3 reserved |
| wr_data | input | 16 | Write data bus |
| ch_en | input | 1 | Channel enable (analog power) |
| wake_cycles | input | 16 | Wakeup delay in clock cycles |
| trig_en | input | 1 | 1 selects trigger-driven transfer, 0 selects automatic transfer |
| trig_sel | input | 4 | External trigger select |
| sw_trig_set | input | 1 | Software trigger request pulse |
| ext_trig | input | 16 | External trigger inputs |
| hold_q | output | 12 | Holding register |
| out_code | output | 12 | Output register, to the converter |
| ready | output | 1 | Channel ready |
| err_sticky | output | 1 | Sticky startup-violation flag |
| sw_pend | output | 1 | Software trigger pending |

## Verification
The assertions assume that wr_en, sw_trig_set, ch_en and the trigger controls are driven synchronously to clk. They also assume that the external triggers are already synchronous, so a single sampling stage is enough for edge detection.

The stimulus changes every input only on the falling clock edge. It lowers ch_en and pulses reset between scenarios, so that each test starts from a known ready state.

The software-pending check assumes that sw_trig_set is not asserted in the same cycle as the transfer it would race. The bench never issues a new software request while one is still pending.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
   typedef enum logic [1:0] {
      FMT_BYTE_R = 2'd0,
      FMT_WORD_L = 2'd1,
      FMT_WORD_R = 2'd2,
      FMT_RSVD   = 2'd3
   } align_fmt_e;
endpackage

// File: rtl/dac_fmt_align.sv
module dac_fmt_align
   import dac_hold_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int IN_W   = 16
) (
   input  logic [1:0]        fmt,
   input  logic [IN_W-1:0]   din,
   output logic              fmt_ok,
   output logic [DATA_W-1:0] aligned
);
   localparam int BYTE_SHIFT = DATA_W - 8;

   logic [DATA_W-1:0] byte_val;

   generate
      if (BYTE_SHIFT > 0) begin : g_byte_pad
         assign byte_val = {din[7:0], {BYTE_SHIFT{1'b0}}};
      end else begin : g_byte_flat
         assign byte_val = din[7:0];
      end
   endgenerate

   always_comb begin
      fmt_ok  = 1'b1;
      aligned = '0;
      unique case (align_fmt_e'(fmt))
         FMT_BYTE_R: aligned = byte_val;
         FMT_WORD_L: aligned = din[IN_W-1 -: DATA_W];
         FMT_WORD_R: aligned = din[DATA_W-1:0];
         default:    fmt_ok  = 1'b0;
      endcase
   end
endmodule

// File: rtl/dac_wake_seq.sv
module dac_wake_seq #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] wake_cycles,
   output logic             ready
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             rdy_q;
   logic [EXT_W-1:0] cnt_next;

   assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rdy_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         rdy_q <= 1'b0;
      end else if (!rdy_q) begin
         cnt_q <= cnt_next[CNT_W-1:0];
         if (cnt_next >= {1'b0, wake_cycles}) rdy_q <= 1'b1;
      end
   end

   assign ready = rdy_q & en;
endmodule

// File: rtl/dac_trig_edge.sv
module dac_trig_edge #(
   parameter int NUM_TRIG = 16,
   parameter int SEL_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    sel,
   input  logic [NUM_TRIG-1:0] trig_in,
   output logic                rise
);
   localparam int SLOTS = 1 << SEL_W;

   logic [SLOTS-1:0] padded;
   logic             samp_q;
   logic             prev_q;

   generate
      if (SLOTS > NUM_TRIG) begin : g_pad
         assign padded = {{(SLOTS-NUM_TRIG){1'b0}}, trig_in};
      end else begin : g_full
         assign padded = trig_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         samp_q <= padded[sel];
         prev_q <= samp_q;
      end
   end

   assign rise = samp_q & ~prev_q;
endmodule

// File: rtl/dac_hold_front.sv
module dac_hold_front #(
   parameter int DATA_W   = 12,
   parameter int IN_W     = 16,
   parameter int NUM_TRIG = 16,
   parameter int SEL_W    = 4,
   parameter int CNT_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_fmt,
   input  logic [IN_W-1:0]     wr_data,
   input  logic                ch_en,
   input  logic [CNT_W-1:0]    wake_cycles,
   input  logic                trig_en,
   input  logic [SEL_W-1:0]    trig_sel,
   input  logic                sw_trig_set,
   input  logic [NUM_TRIG-1:0] ext_trig,
   output logic [DATA_W-1:0]   hold_q,
   output logic [DATA_W-1:0]   out_code,
   output logic                ready,
   output logic                err_sticky,
   output logic                sw_pend
);
   generate
      if (DATA_W < 8 || IN_W < DATA_W) begin : g_bad_width
         $error("dac_hold_front: need 8 <= DATA_W <= IN_W");
      end
      if (NUM_TRIG < 1 || NUM_TRIG > (1 << SEL_W)) begin : g_bad_trig
         $error("dac_hold_front: NUM_TRIG must fit the select field");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("dac_hold_front: CNT_W must be positive");
      end
   endgenerate

   logic              fmt_ok;
   logic [DATA_W-1:0] aligned;
   logic              ext_rise;
   logic              busy;
   logic              wr_take;
   logic              sw_fire;
   logic              ext_fire;
   logic              xfer;
   logic              violation;
   logic              auto_pend_q;

   dac_fmt_align #(.DATA_W(DATA_W), .IN_W(IN_W)) u_align (
      .fmt     (wr_fmt),
      .din     (wr_data),
      .fmt_ok  (fmt_ok),
      .aligned (aligned)
   );

   dac_wake_seq #(.CNT_W(CNT_W)) u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (ch_en),
      .wake_cycles (wake_cycles),
      .ready       (ready)
   );

   dac_trig_edge #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (trig_sel),
      .trig_in (ext_trig),
      .rise    (ext_rise)
   );

   assign busy      = ch_en & ~ready;
   assign wr_take   = wr_en & fmt_ok & ~busy;
   assign sw_fire   = sw_pend & trig_en & ~busy;
   assign ext_fire  = ext_rise & trig_en & ~busy;
   assign xfer      = auto_pend_q | sw_fire | ext_fire;
   assign violation = busy & (wr_en | sw_trig_set | (trig_en & ext_rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         out_code    <= '0;
         auto_pend_q <= 1'b0;
         sw_pend     <= 1'b0;
         err_sticky  <= 1'b0;
      end else begin
         if (wr_take) hold_q <= aligned;
         auto_pend_q <= wr_take & ~trig_en;
         if (xfer) out_code <= hold_q;
         if (sw_trig_set && !busy) sw_pend <= 1'b1;
         else if (sw_fire)         sw_pend <= 1'b0;
         if (violation) err_sticky <= 1'b1;
      end
   end
endmodule

// File: rtl/dac_hold_front_chk.sv
module dac_hold_front_chk #(
   parameter int DATA_W   = 12,
   parameter int IN_W     = 16,
   parameter int NUM_TRIG = 16,
   parameter int SEL_W    = 4,
   parameter int CNT_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [1:0]          wr_fmt,
   input logic [IN_W-1:0]     wr_data,
   input logic                ch_en,
   input logic                trig_en,
   input logic                sw_trig_set,
   input logic [DATA_W-1:0]   hold_q,
   input logic [DATA_W-1:0]   out_code,
   input logic                ready,
   input logic                err_sticky,
   input logic                sw_pend
);
   logic busy;
   logic take;
   assign busy = ch_en & ~ready;
   assign take = wr_en & ~busy & (wr_fmt != 2'd3);

   AST_BYTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wr_fmt == 2'd0) |=> (hold_q[DATA_W-1 -: 8] == $past(wr_data[7:0]))); // R2

   AST_WORD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wr_fmt == 2'd2) |=> (hold_q == $past(wr_data[DATA_W-1:0]))); // R4

   AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_fmt == 2'd3) |=> $stable(hold_q)); // R5

   AST_AUTO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !trig_en) |=> ##1 (out_code == $past(hold_q))); // R6

   AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pend && trig_en && !busy && !sw_trig_set) |=> !sw_pend); // R7

   AST_READY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(ch_en)); // R9

   AST_BUSY_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(hold_q)); // R10

   AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> err_sticky); // R10

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky); // R10

   AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en && !err_sticky) |=> !err_sticky); // R11
endmodule

bind dac_hold_front dac_hold_front_chk #(
   .DATA_W(DATA_W), .IN_W(IN_W), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_fmt      (wr_fmt),
   .wr_data     (wr_data),
   .ch_en       (ch_en),
   .trig_en     (trig_en),
   .sw_trig_set (sw_trig_set),
   .hold_q      (hold_q),
   .out_code    (out_code),
   .ready       (ready),
   .err_sticky  (err_sticky),
   .sw_pend     (sw_pend)
);

// File: tb/tb_dac_hold_front.sv
`timescale 1ns/1ps
module tb_dac_hold_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_fmt = 2'd0;
   logic [15:0] wr_data = '0;
   logic        ch_en = 1'b0;
   logic [15:0] wake_cycles = 16'd0;
   logic        trig_en = 1'b0;
   logic [3:0]  trig_sel = 4'd0;
   logic        sw_trig_set = 1'b0;
   logic [15:0] ext_trig = '0;
   logic [11:0] hold_q;
   logic [11:0] out_code;
   logic        ready;
   logic        err_sticky;
   logic        sw_pend;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   dac_hold_front dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fmt(wr_fmt), .wr_data(wr_data),
      .ch_en(ch_en), .wake_cycles(wake_cycles), .trig_en(trig_en), .trig_sel(trig_sel),
      .sw_trig_set(sw_trig_set), .ext_trig(ext_trig), .hold_q(hold_q), .out_code(out_code),
      .ready(ready), .err_sticky(err_sticky), .sw_pend(sw_pend)
   );

   // {fmt, write data, expected holding value}
   localparam logic [29:0] VEC [8] = '{
      {2'd0, 16'hFFA5, 12'hA50},
      {2'd0, 16'h003C, 12'h3C0},
      {2'd1, 16'hABCD, 12'hABC},
      {2'd1, 16'h123F, 12'h123},
      {2'd2, 16'hF9E7, 12'h9E7},
      {2'd2, 16'h0FFF, 12'hFFF},
      {2'd0, 16'h0000, 12'h000},
      {2'd1, 16'h8000, 12'h800}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0; sw_trig_set = 1'b0; ch_en = 1'b0; trig_en = 1'b0; ext_trig = '0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive a write for one edge; returns at the negedge after that edge
   task automatic wr(input logic [1:0] f, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_fmt = f; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 hold", 16'(hold_q), 16'h0);
      chk("R1 out", 16'(out_code), 16'h0);
      chk("R1 ready", 16'(ready), 16'h0);
      chk("R1 err", 16'(err_sticky), 16'h0);
      chk("R1 swpend", 16'(sw_pend), 16'h0);
      rst_n = 1'b1;

      // Table walk: formats R2 R3 R4, automatic transfer R6, enable low R11
      for (int i = 0; i < 8; i++) begin
         logic [11:0] prev_out;
         prev_out = out_code;
         wr(VEC[i][29:28], VEC[i][27:12]);
         chk("R2/R3/R4 hold", 16'(hold_q), 16'(VEC[i][11:0]));
         chk("R6 out not yet", 16'(out_code), 16'(prev_out));
         @(negedge clk);
         chk("R6 out copied", 16'(out_code), 16'(VEC[i][11:0]));
      end
      chk("R11 no error", 16'(err_sticky), 16'h0);

      // R5 reserved format ignored
      wr(2'd2, 16'h0321);
      @(negedge clk);
      wr(2'd3, 16'hFFFF);
      chk("R5 hold kept", 16'(hold_q), 16'h321);
      @(negedge clk);
      chk("R5 out kept", 16'(out_code), 16'h321);
      chk("R5 no error", 16'(err_sticky), 16'h0);

      // R7 software trigger
      trig_en = 1'b1;
      wr(2'd2, 16'h0456);
      @(negedge clk);
      chk("R7 write alone no transfer", 16'(out_code), 16'h321);
      sw_trig_set = 1'b1;
      @(negedge clk);
      sw_trig_set = 1'b0;
      chk("R7 pending set", 16'(sw_pend), 16'h1);
      chk("R7 out before", 16'(out_code), 16'h321);
      @(negedge clk);
      chk("R7 out after", 16'(out_code), 16'h456);
      chk("R7 pending cleared", 16'(sw_pend), 16'h0);

      // R8 external trigger select and edge
      trig_sel = 4'd5;
      wr(2'd2, 16'h0789);
      ext_trig[3] = 1'b1;
      repeat (3) @(negedge clk);
      ext_trig[3] = 1'b0;
      chk("R8 unselected ignored", 16'(out_code), 16'h456);
      ext_trig[5] = 1'b1;
      @(negedge clk);
      chk("R8 not yet", 16'(out_code), 16'h456);
      @(negedge clk);
      chk("R8 edge transfer", 16'(out_code), 16'h789);
      wr(2'd2, 16'h0111);
      repeat (3) @(negedge clk);
      chk("R8 level no repeat", 16'(out_code), 16'h789);
      ext_trig[5] = 1'b0;
      @(negedge clk);

      // R9 wakeup count
      do_reset();
      wake_cycles = 16'd5;
      @(negedge clk);
      ch_en = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         chk("R9 ready timing", 16'(ready), (k == 5) ? 16'h1 : 16'h0);
      end
      ch_en = 1'b0;
      #1;
      chk("R9 ready drops", 16'(ready), 16'h0);
      wake_cycles = 16'd0;
      @(negedge clk);
      ch_en = 1'b1;
      @(negedge clk);
      chk("R9 zero wake", 16'(ready), 16'h1);

      // R10 startup violations
      do_reset();
      wake_cycles = 16'd20;
      trig_en = 1'b1;
      trig_sel = 4'd2;
      @(negedge clk);
      ch_en = 1'b1;
      wr(2'd2, 16'h0ABC);
      chk("R10 write ignored", 16'(hold_q), 16'h0);
      chk("R10 err set", 16'(err_sticky), 16'h1);
      sw_trig_set = 1'b1;
      @(negedge clk);
      sw_trig_set = 1'b0;
      chk("R10 sw ignored", 16'(sw_pend), 16'h0);
      ext_trig[2] = 1'b1;
      repeat (2) @(negedge clk);
      ext_trig[2] = 1'b0;
      chk("R10 ext ignored", 16'(out_code), 16'h0);
      for (int k = 0; k < 30 && !ready; k++) @(negedge clk);
      chk("R10 ready reached", 16'(ready), 16'h1);
      wr(2'd1, 16'h5550);
      chk("R10 write after ready", 16'(hold_q), 16'h555);
      chk("R10 err sticky", 16'(err_sticky), 16'h1);

      do_reset();
      chk("R1 err cleared", 16'(err_sticky), 16'h0);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule